// File: doc/BRIEF.md
# Two-List Proportional Slot Interleaver

The block merges two lists of slot owner codes into one output sequence, so that the entries of the sparser list end up spread evenly among the entries of the denser one. Software or a neighbouring engine first fills both lists through a write port that takes a list select, an index and a code. It then pulses `start`. The block counts the occupied entries of each list and decides which list is the short one. A multi-cycle restoring divider computes the pacing ratio. The block then streams the merged codes out, one per `out_valid` strobe, and raises `done` at the end.

The pacing comes from a signed score counter, not from simple alternation. Each pick from the short list adds a fixed credit of 100000 to the counter. Each pick from the long list subtracts the ratio 100000·S/L, rounded down, where S and L are the occupied counts of the two lists. After each short pick, long entries follow for as long as the counter stays positive. A round that takes nothing from either list stops the merge and raises `error`. Every entry that is taken is overwritten with the empty code. After a merge, both lists are therefore empty unless they are reloaded.

Top module: `slot_interleaver`

## Requirements
- R1: After a synchronous reset, `busy`, `done`, `error` and `out_valid` are all low.
- R2: The list with fewer occupied entries is the short list. If the counts are equal, the new list (`wr_sel`=1) is the short one; otherwise the existing list is `wr_sel`=0. When the counts are equal and non-zero, the first merged code is the first occupied entry of the new list.
- R3: The merged order follows the score rule. The ratio is T = floor(100000·S/L), or T = 0 when L = 0. The score starts at 0. Each round takes one short entry, if any remain, and adds 100000 to the score. It then takes long entries one at a time while any remain and the score is above zero, subtracting T for each.
- R4: An entry whose code is all ones (63 at the default 6-bit width) is empty and is never output. Each list is consumed in ascending index order. Every occupied entry appears exactly once.
- R5: When both lists are exhausted, `done` goes high and `busy` goes low. If both lists start empty, `done` rises with no output at all.
- R6: If a round takes nothing from either list, `error` goes high, `done` stays low and `busy` goes low, and no further codes are output. This happens, for example, when exactly one list is empty.
- R7: Each consumed entry is overwritten with the empty code. After a successful merge, a new `start` without reloading produces no output and ends with `done`.
- R8: While `busy` is high, `start` pulses and list writes are ignored. The running sequence is unchanged, and the lists written during the run stay as the merge left them.
- R9: `busy` is high from the cycle after an accepted `start`, through the counting, the division and the merge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | List write strobe, honoured only when not busy |
| wr_sel | input | 1 | List select: 0 existing list, 1 new list |
| wr_idx | input | 6 | Entry index written |
| wr_code | input | 6 | Code written; all ones marks the entry empty |
| start | input | 1 | Pulse that begins a merge, honoured only when not busy |
| busy | output | 1 | Merge in progress, divider phase included |
| done | output | 1 | Last merge ended normally; held until the next start |
| error | output | 1 | Last merge stopped on a round without progress; held until the next start |
| out_valid | output | 1 | One-cycle strobe qualifying `out_code` |
| out_code | output | 6 | Merged slot owner code |

## Verification
A wrong short/long decision or a wrong ratio shows up within the first few strobes. The first code would come from the wrong list, or the run of long codes after a short code would have the wrong length. A pointer that skips an occupied entry or revisits one changes the stream the moment that entry is reached. It also breaks the count of strobes before `done`. A failure to clear consumed entries shows only on the next `start`, which would emit codes again instead of finishing silently. Random list fills with random holes are compared, code by code, with a model of the score rule.

// File: rtl/sli_pkg.sv
`timescale 1ns/1ps
package sli_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_SCAN,
    ST_SCAN_LAST,
    ST_DECIDE,
    ST_DIV_GO,
    ST_DIV_WAIT,
    ST_CHECK,
    ST_STEP_S,
    ST_LONG,
    ST_TK_RD,
    ST_TK_CHK,
    ST_ROUND_END
  } sli_state_t;

endpackage

// File: rtl/sli_list_mem.sv
`timescale 1ns/1ps
// One slot list: simple dual-port storage with a registered read,
// shaped so that a block RAM can be inferred.
module sli_list_mem #(
  parameter int CODE_W = 6,
  parameter int DEPTH  = 64,
  parameter int AW     = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [CODE_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [CODE_W-1:0] rdata
);

  logic [CODE_W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
    rdata <= store[raddr];
  end

endmodule

// File: rtl/sli_divider.sv
`timescale 1ns/1ps
// Restoring divider: one quotient bit per cycle, NUM_W cycles after go.
module sli_divider #(
  parameter int NUM_W = 23,
  parameter int DEN_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             go,
  input  logic [NUM_W-1:0] num,
  input  logic [DEN_W-1:0] den,
  output logic             fin,
  output logic [NUM_W-1:0] quo
);

  localparam int STEP_W = $clog2(NUM_W + 1);

  logic [DEN_W-1:0]  rem_q;
  logic [DEN_W-1:0]  den_q;
  logic [STEP_W-1:0] left_q;
  logic              run_q;
  logic [DEN_W:0]    shifted;
  logic [DEN_W:0]    diff;
  logic              fits;

  assign shifted = {rem_q, quo[NUM_W-1]};
  assign diff    = shifted - {1'b0, den_q};
  assign fits    = ~diff[DEN_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q  <= '0;
      den_q  <= '0;
      left_q <= '0;
      run_q  <= 1'b0;
      fin    <= 1'b0;
      quo    <= '0;
    end else begin
      fin <= 1'b0;
      if (go && !run_q) begin
        quo    <= num;
        den_q  <= den;
        rem_q  <= '0;
        left_q <= STEP_W'(NUM_W);
        run_q  <= 1'b1;
      end else if (run_q) begin
        if (fits) begin
          rem_q <= diff[DEN_W-1:0];
          quo   <= {quo[NUM_W-2:0], 1'b1};
        end else begin
          rem_q <= shifted[DEN_W-1:0];
          quo   <= {quo[NUM_W-2:0], 1'b0};
        end
        left_q <= left_q - STEP_W'(1);
        if (left_q == STEP_W'(1)) begin
          run_q <= 1'b0;
          fin   <= 1'b1;
        end
      end
    end
  end

  AST_DIV_DEN_NONZERO: assert property (@(posedge clk) disable iff (rst)
    (go && !run_q) |-> (den != '0)); // R3

endmodule

// File: rtl/slot_interleaver.sv
`timescale 1ns/1ps
module slot_interleaver import sli_pkg::*; #(
  parameter int CODE_W = 6,
  parameter int DEPTH  = 64,
  parameter int CREDIT = 100000
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic                     wr_sel,
  input  logic [$clog2(DEPTH)-1:0] wr_idx,
  input  logic [CODE_W-1:0]        wr_code,
  input  logic                     start,
  output logic                     busy,
  output logic                     done,
  output logic                     error,
  output logic                     out_valid,
  output logic [CODE_W-1:0]        out_code
);

  localparam int AW    = $clog2(DEPTH);
  localparam int CW    = $clog2(DEPTH + 1);
  localparam int NUM_W = $clog2(CREDIT * DEPTH + 1);
  localparam int SW    = NUM_W + 2;
  localparam logic [CODE_W-1:0]    EMPTY     = '1;
  localparam logic [AW-1:0]        LAST_ADDR = AW'(DEPTH - 1);
  localparam logic signed [SW-1:0] CREDIT_S  = SW'(CREDIT);

  sli_state_t st_q;

  logic [AW-1:0]        scan_addr_q;
  logic                 scan_pend_q;
  logic [CW-1:0]        cnt_old_q, cnt_new_q;
  logic [CW-1:0]        rem_s_q, rem_l_q;
  logic [AW-1:0]        ptr_q [2];
  logic                 short_new_q;
  logic                 take_long_q;
  logic                 act_q;
  logic signed [SW-1:0] score_q;
  logic [NUM_W-1:0]     tgt_q;

  logic                 tk_list;
  logic [CODE_W-1:0]    cur_data;
  logic                 clr_we;
  logic                 score_pos;
  logic                 new_longer;

  logic                 mem_we    [2];
  logic [AW-1:0]        mem_waddr [2];
  logic [CODE_W-1:0]    mem_wdata [2];
  logic [AW-1:0]        mem_raddr [2];
  logic [CODE_W-1:0]    mem_rdata [2];

  logic                 div_go;
  logic                 div_fin;
  logic [NUM_W-1:0]     div_num;
  logic [NUM_W-1:0]     div_quo;

  // physical list being taken from: 1 = new list
  assign tk_list    = take_long_q ? ~short_new_q : short_new_q;
  assign cur_data   = mem_rdata[tk_list];
  assign clr_we     = (st_q == ST_TK_CHK) && (cur_data != EMPTY);
  assign score_pos  = !score_q[SW-1] && (score_q != '0);
  assign new_longer = cnt_new_q > cnt_old_q;

  for (genvar g = 0; g < 2; g++) begin : g_list
    assign mem_we[g]    = busy ? (clr_we && (tk_list == 1'(g)))
                               : (wr_en && (wr_sel == 1'(g)));
    assign mem_waddr[g] = busy ? ptr_q[g] : wr_idx;
    assign mem_wdata[g] = busy ? EMPTY : wr_code;
    assign mem_raddr[g] = (st_q == ST_SCAN) ? scan_addr_q : ptr_q[g];

    sli_list_mem #(
      .CODE_W (CODE_W),
      .DEPTH  (DEPTH),
      .AW     (AW)
    ) u_mem (
      .clk   (clk),
      .we    (mem_we[g]),
      .waddr (mem_waddr[g]),
      .wdata (mem_wdata[g]),
      .raddr (mem_raddr[g]),
      .rdata (mem_rdata[g])
    );
  end

  assign div_go  = (st_q == ST_DIV_GO) && (rem_l_q != '0);
  assign div_num = NUM_W'(CREDIT) * NUM_W'(rem_s_q);

  sli_divider #(
    .NUM_W (NUM_W),
    .DEN_W (CW)
  ) u_div (
    .clk (clk),
    .rst (rst),
    .go  (div_go),
    .num (div_num),
    .den (rem_l_q),
    .fin (div_fin),
    .quo (div_quo)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q        <= ST_IDLE;
      busy        <= 1'b0;
      done        <= 1'b0;
      error       <= 1'b0;
      out_valid   <= 1'b0;
      out_code    <= EMPTY;
      scan_addr_q <= '0;
      scan_pend_q <= 1'b0;
      cnt_old_q   <= '0;
      cnt_new_q   <= '0;
      rem_s_q     <= '0;
      rem_l_q     <= '0;
      ptr_q[0]    <= '0;
      ptr_q[1]    <= '0;
      short_new_q <= 1'b0;
      take_long_q <= 1'b0;
      act_q       <= 1'b0;
      score_q     <= '0;
      tgt_q       <= '0;
    end else begin
      out_valid <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (start) begin
            busy        <= 1'b1;
            done        <= 1'b0;
            error       <= 1'b0;
            scan_addr_q <= '0;
            scan_pend_q <= 1'b0;
            cnt_old_q   <= '0;
            cnt_new_q   <= '0;
            ptr_q[0]    <= '0;
            ptr_q[1]    <= '0;
            score_q     <= '0;
            act_q       <= 1'b0;
            st_q        <= ST_SCAN;
          end
        end
        ST_SCAN: begin
          scan_pend_q <= 1'b1;
          if (scan_pend_q) begin
            cnt_old_q <= cnt_old_q + CW'(mem_rdata[0] != EMPTY);
            cnt_new_q <= cnt_new_q + CW'(mem_rdata[1] != EMPTY);
          end
          scan_addr_q <= scan_addr_q + AW'(1);
          if (scan_addr_q == LAST_ADDR) st_q <= ST_SCAN_LAST;
        end
        ST_SCAN_LAST: begin
          cnt_old_q   <= cnt_old_q + CW'(mem_rdata[0] != EMPTY);
          cnt_new_q   <= cnt_new_q + CW'(mem_rdata[1] != EMPTY);
          scan_pend_q <= 1'b0;
          st_q        <= ST_DECIDE;
        end
        ST_DECIDE: begin
          short_new_q <= !new_longer;
          rem_s_q     <= new_longer ? cnt_old_q : cnt_new_q;
          rem_l_q     <= new_longer ? cnt_new_q : cnt_old_q;
          st_q        <= ST_DIV_GO;
        end
        ST_DIV_GO: begin
          if (rem_l_q == '0) begin
            tgt_q <= '0;
            st_q  <= ST_CHECK;
          end else begin
            st_q <= ST_DIV_WAIT;
          end
        end
        ST_DIV_WAIT: begin
          if (div_fin) begin
            tgt_q <= div_quo;
            st_q  <= ST_CHECK;
          end
        end
        ST_CHECK: begin
          if (rem_s_q == '0 && rem_l_q == '0) begin
            busy <= 1'b0;
            done <= 1'b1;
            st_q <= ST_IDLE;
          end else begin
            act_q <= 1'b0;
            st_q  <= ST_STEP_S;
          end
        end
        ST_STEP_S: begin
          if (rem_s_q != '0) begin
            take_long_q <= 1'b0;
            st_q        <= ST_TK_RD;
          end else begin
            st_q <= ST_LONG;
          end
        end
        ST_LONG: begin
          if (rem_l_q != '0 && score_pos) begin
            take_long_q <= 1'b1;
            st_q        <= ST_TK_RD;
          end else begin
            st_q <= ST_ROUND_END;
          end
        end
        ST_TK_RD: st_q <= ST_TK_CHK;
        ST_TK_CHK: begin
          ptr_q[tk_list] <= ptr_q[tk_list] + AW'(1);
          if (cur_data != EMPTY) begin
            out_valid <= 1'b1;
            out_code  <= cur_data;
            act_q     <= 1'b1;
            if (take_long_q) begin
              rem_l_q <= rem_l_q - CW'(1);
              score_q <= score_q - $signed({2'b00, tgt_q});
            end else begin
              rem_s_q <= rem_s_q - CW'(1);
              score_q <= score_q + CREDIT_S;
            end
            st_q <= ST_LONG;
          end else begin
            st_q <= ST_TK_RD;
          end
        end
        ST_ROUND_END: begin
          if (!act_q) begin
            busy  <= 1'b0;
            error <= 1'b1;
            st_q  <= ST_IDLE;
          end else begin
            st_q <= ST_CHECK;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  AST_OUT_NOT_EMPTY: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_code != EMPTY) && busy); // R4

  AST_PTR_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_TK_CHK && cur_data == EMPTY) |-> (ptr_q[tk_list] != LAST_ADDR)); // R4

  AST_DONE_EXHAUSTED: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> (rem_s_q == '0) && (rem_l_q == '0)); // R5

  AST_DONE_NOT_ERR: assert property (@(posedge clk) disable iff (rst)
    done |-> !error); // R6

  AST_ERR_SILENT: assert property (@(posedge clk) disable iff (rst)
    error |=> !out_valid); // R6

  AST_DIV_EXACT: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_DIV_WAIT && div_fin) |->
      (64'(div_quo) * 64'(rem_l_q) <= 64'(div_num)) &&
      (64'(div_num) < (64'(div_quo) + 64'd1) * 64'(rem_l_q))); // R3

  AST_BUSY_IN_DIV: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_DIV_WAIT) |-> busy); // R9

endmodule

// File: tb/slot_interleaver_bench.sv
`timescale 1ns/1ps
module slot_interleaver_bench;

  localparam int W     = 6;
  localparam int DEPTH = 64;
  localparam logic [W-1:0] EMP = '1;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         wr_en = 1'b0;
  logic         wr_sel = 1'b0;
  logic [5:0]   wr_idx = '0;
  logic [W-1:0] wr_code = '0;
  logic         start = 1'b0;
  logic         busy, done, error, out_valid;
  logic [W-1:0] out_code;

  always #2.5 clk = ~clk;

  slot_interleaver #(.CODE_W(W), .DEPTH(DEPTH), .CREDIT(100000)) u_slot_interleaver (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_idx(wr_idx),
    .wr_code(wr_code), .start(start), .busy(busy), .done(done), .error(error),
    .out_valid(out_valid), .out_code(out_code)
  );

  int checks = 0;
  int fails  = 0;

  logic [W-1:0] m_list  [2][DEPTH];
  logic [W-1:0] exp_seq [2*DEPTH];
  logic [W-1:0] got_seq [2*DEPTH];
  int exp_n, got_n;
  bit exp_err;

  task automatic check(input string tag, input longint act, input longint expv);
    checks++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  // score-rule model; also predicts list contents after the run
  task automatic compute_model();
    int co, cn, s_n, l_n, ls, ll, si, li;
    int sidx [DEPTH];
    int lidx [DEPTH];
    longint tgt, score;
    bit act;
    co = 0; cn = 0;
    for (int i = 0; i < DEPTH; i++) begin
      if (m_list[0][i] != EMP) co++;
      if (m_list[1][i] != EMP) cn++;
    end
    ls = (cn > co) ? 0 : 1;
    ll = 1 - ls;
    s_n = 0; l_n = 0;
    for (int i = 0; i < DEPTH; i++) begin
      if (m_list[ls][i] != EMP) begin sidx[s_n] = i; s_n++; end
      if (m_list[ll][i] != EMP) begin lidx[l_n] = i; l_n++; end
    end
    tgt = (l_n == 0) ? 0 : (100000 * s_n) / l_n;
    score = 0; si = 0; li = 0; exp_n = 0; exp_err = 1'b0;
    while (si < s_n || li < l_n) begin
      act = 1'b0;
      if (si < s_n) begin
        exp_seq[exp_n] = m_list[ls][sidx[si]]; exp_n++;
        m_list[ls][sidx[si]] = EMP; si++;
        score += 100000; act = 1'b1;
      end
      while (li < l_n && score > 0) begin
        exp_seq[exp_n] = m_list[ll][lidx[li]]; exp_n++;
        m_list[ll][lidx[li]] = EMP; li++;
        score -= tgt; act = 1'b1;
      end
      if (!act) begin exp_err = 1'b1; break; end
    end
  endtask

  task automatic load_lists();
    for (int l = 0; l < 2; l++)
      for (int i = 0; i < DEPTH; i++) begin
        @(negedge clk);
        wr_en = 1'b1; wr_sel = l[0]; wr_idx = i[5:0]; wr_code = m_list[l][i];
      end
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic clear_model();
    for (int l = 0; l < 2; l++)
      for (int i = 0; i < DEPTH; i++) m_list[l][i] = EMP;
  endtask

  task automatic run(input string tag, input bit disturb);
    int cyc;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    check({tag, " R9 busy after start"}, busy, 1);
    got_n = 0; cyc = 0;
    while (!(done || error) && cyc < 20000) begin
      if (disturb && (cyc % 7 == 3)) begin
        start = 1'b1; wr_en = 1'b1; wr_sel = cyc[0];
        wr_idx = cyc[5:0]; wr_code = 6'd5;
      end else begin
        start = 1'b0; wr_en = 1'b0;
      end
      @(negedge clk);
      cyc++;
      if (out_valid && got_n < 2*DEPTH) begin
        got_seq[got_n] = out_code; got_n++;
      end
    end
    start = 1'b0; wr_en = 1'b0;
    check({tag, " run finished"}, (cyc < 20000) ? 1 : 0, 1);
  endtask

  task automatic compare(input string tag);
    int bad;
    check({tag, " R6 error flag"}, error, exp_err);
    check({tag, " R5 done flag"}, done, !exp_err);
    check({tag, " R5 busy cleared"}, busy, 0);
    check({tag, " R4 output count"}, got_n, exp_n);
    bad = -1;
    for (int i = 0; i < exp_n && i < got_n; i++)
      if (bad < 0 && got_seq[i] != exp_seq[i]) bad = i;
    if (bad >= 0) check({tag, " R3 merged code"}, got_seq[bad], exp_seq[bad]);
    else check({tag, " R3 merged code"}, 0, 0);
  endtask

  task automatic do_test(input string tag, input bit reload, input bit disturb);
    if (reload) load_lists();
    compute_model();
    run(tag, disturb);
    compare(tag);
  endtask

  initial begin
    #750000;
    fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [W-1:0] first_new;
    int pa, pb;
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 busy reset", busy, 0);
    check("R1 done reset", done, 0);
    check("R1 error reset", error, 0);
    check("R1 out_valid reset", out_valid, 0);

    // equal counts: new list is the short one
    clear_model();
    for (int i = 0; i < 3; i++) begin m_list[0][i] = W'(10 + i); m_list[1][i] = W'(20 + i); end
    first_new = m_list[1][0];
    do_test("T1 equal", 1'b1, 1'b0);
    check("R2 tie picks new list first", got_seq[0], first_new);

    // new list longer, holes in both
    clear_model();
    m_list[0][4] = 6'd1; m_list[0][40] = 6'd2;
    m_list[1][0] = 6'd30; m_list[1][7] = 6'd31; m_list[1][8] = 6'd32;
    m_list[1][50] = 6'd33; m_list[1][63] = 6'd34;
    do_test("T2 sparse", 1'b1, 1'b0);
    check("R2 shorter old list first", got_seq[0], 6'd1);

    // rerun without reload: consumed entries are empty
    do_test("T3 R7 rerun", 1'b0, 1'b0);

    // both empty
    clear_model();
    do_test("T4 R5 both empty", 1'b1, 1'b0);

    // one list empty: no progress
    clear_model();
    for (int i = 0; i < 4; i++) m_list[1][2*i] = W'(40 + i);
    do_test("T5 R6 one empty", 1'b1, 1'b0);
    check("T5 R6 no output", got_n, 0);

    // full lists
    for (int l = 0; l < 2; l++)
      for (int i = 0; i < DEPTH; i++) m_list[l][i] = W'($urandom % 63);
    do_test("T6 full", 1'b1, 1'b0);

    // start and writes during the run are ignored
    clear_model();
    for (int i = 0; i < 10; i++) m_list[0][3*i] = W'(i);
    for (int i = 0; i < 20; i++) m_list[1][i+30] = W'(i + 25);
    do_test("T7 R8 disturbed", 1'b1, 1'b1);
    do_test("T8 R8 writes dropped", 1'b0, 1'b0);

    // random fills
    for (int t = 0; t < 20; t++) begin
      pa = $urandom % 101; pb = $urandom % 101;
      for (int i = 0; i < DEPTH; i++) begin
        m_list[0][i] = (($urandom % 100) < pa) ? W'($urandom % 63) : EMP;
        m_list[1][i] = (($urandom % 100) < pb) ? W'($urandom % 63) : EMP;
      end
      do_test($sformatf("RND%0d R3", t), 1'b1, 1'b0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule